// File: doc/BRIEF.md
# Framed Serial Word Transmitter

This block sends parallel sample words over a framed synchronous serial link. It runs entirely on the serial bit clock. Once per frame it raises a one-cycle frame-sync pulse. On the next bit clock it starts driving the word on the data line, most significant bit first. The frame length is a parameter counted in bit clocks. With the default of 256 cycles and a 2.048 MHz bit clock, one 16-bit word goes out every 125 µs, which is an 8 kHz frame rate.

Transmission depends on two independent operating bits, one analog and one digital, that come from an external control register. Frames are produced only while both bits are 1. When both bits become set, the block waits through a parameterised warm-up interval before the first frame. If either bit clears, the block finishes the frame in progress, stops at the next frame boundary and returns to idle. From idle, another full warm-up is needed before frames start again.

Samples arrive on a valid/ready handshake that is sampled once per frame, in the cycle before the frame sync rises. If no sample is offered at that point, the block sends the previous word again.

Top module: `ftx_serial_tx`

## Requirements
- R1: While either `pwr_ana_ok` or `pwr_dig_ok` is 0, `fsync`, `sdo` and `s_ready` all stay low and no frame is started.
- R2: Both enables must first be sampled high on some rising edge. Counting that edge as the first, `fsync` rises on rising edge number STARTUP_CYCLES+2. If an enable drops during this warm-up, the block returns to idle without a frame, and the next enabling starts the full delay again.
- R3: While enabled, consecutive `fsync` pulses are exactly FRAME_CYCLES bit clocks apart.
- R4: `fsync` is high for exactly one bit-clock cycle per frame.
- R5: The word is driven on `sdo` MSB first, one bit per cycle, starting in the cycle right after the `fsync` cycle, for WORD_W consecutive cycles. Outside those cycles `sdo` is low.
- R6: `s_ready` is high only in the cycle just before `fsync` rises. A word offered with `s_valid` high in that cycle is the word sent in that frame.
- R7: If `s_valid` is low in the `s_ready` cycle, the previously sent word is sent again. Until the first word is accepted after reset, that word is all zeros.
- R8: When an enable drops in the middle of a frame, the word in progress still completes. No further `fsync` follows, `sdo` stays low, and restarting takes the full warm-up of R2.
- R9: Synchronous active-high `rst` forces `fsync`, `sdo` and `s_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial bit clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ana_ok | input | 1 | Analog operating bit from the control register |
| pwr_dig_ok | input | 1 | Digital operating bit from the control register |
| s_valid | input | 1 | Sample word offered |
| s_data | input | WORD_W | Sample word |
| s_ready | output | 1 | Sample accepted on this edge when s_valid is high |
| sdo | output | 1 | Serial data, MSB first |
| fsync | output | 1 | One-cycle frame-sync pulse |

## Verification
Three situations are hard to reach from the ports. The first is an enable falling partway through a frame, where the remaining bits of the word must still appear but no new frame may start. The second is the same drop during the warm-up interval, where no frame must ever appear. The third is a frame-start cycle with no sample offered. The stimulus drops an enable a few cycles after an observed sync pulse, and separately halfway through the warm-up. It then re-enables the block and measures the full latency again. It also holds `s_valid` low across whole frames between stretches of randomly offered samples, so that every sent word can be compared with the last word the model saw accepted.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
  typedef enum logic [1:0] {
    FTX_IDLE = 2'd0,
    FTX_WARM = 2'd1,
    FTX_RUN  = 2'd2
  } ftx_state_e;
endpackage

// File: rtl/ftx_sequencer.sv
module ftx_sequencer
  import ftx_pkg::*;
#(
  parameter int FRAME_CYCLES   = 256,
  parameter int STARTUP_CYCLES = 40,
  parameter int WORD_W         = 16
) (
  input  logic sclk,
  input  logic rst,
  input  logic en,
  output logic frame_go,
  output logic bit_go
);
  localparam int PH_W = $clog2(FRAME_CYCLES);
  localparam int WU_W = $clog2(STARTUP_CYCLES) + 1;
  localparam logic [PH_W-1:0] PH_LAST  = PH_W'(FRAME_CYCLES - 1);
  localparam logic [PH_W-1:0] PH_WORD  = PH_W'(WORD_W);
  localparam logic [WU_W-1:0] WU_LAST  = WU_W'(STARTUP_CYCLES - 1);

  ftx_state_e      state;
  logic [PH_W-1:0] ph;
  logic [WU_W-1:0] wu;

  assign frame_go = (state == FTX_RUN) && (ph == '0) && en;
  assign bit_go   = (state == FTX_RUN) && (ph != '0) && (ph <= PH_WORD);

  always_ff @(posedge sclk) begin
    if (rst) begin
      state <= FTX_IDLE;
      ph    <= '0;
      wu    <= '0;
    end else begin
      case (state)
        FTX_IDLE: begin
          ph <= '0;
          wu <= '0;
          if (en) state <= FTX_WARM;
        end
        FTX_WARM: begin
          if (!en) begin
            state <= FTX_IDLE;
          end else if (wu == WU_LAST) begin
            state <= FTX_RUN;
            ph    <= '0;
          end else begin
            wu <= wu + 1'b1;
          end
        end
        FTX_RUN: begin
          if ((ph == '0) && !en) begin
            state <= FTX_IDLE;
          end else begin
            ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
          end
        end
        default: state <= FTX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ftx_word_hold.sv
module ftx_word_hold #(
  parameter int WORD_W = 16
) (
  input  logic              sclk,
  input  logic              rst,
  input  logic              take,
  input  logic              s_valid,
  input  logic [WORD_W-1:0] s_data,
  output logic [WORD_W-1:0] word_next
);
  logic [WORD_W-1:0] held;

  assign word_next = s_valid ? s_data : held;

  always_ff @(posedge sclk) begin
    if (rst)       held <= '0;
    else if (take) held <= word_next;
  end
endmodule

// File: rtl/ftx_shifter.sv
module ftx_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              sclk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift,
  output logic              sdo_q
);
  logic [WORD_W-1:0] sh;

  always_ff @(posedge sclk) begin
    if (rst) begin
      sh    <= '0;
      sdo_q <= 1'b0;
    end else if (load) begin
      sh    <= load_word;
      sdo_q <= 1'b0;
    end else if (shift) begin
      sdo_q <= sh[WORD_W-1];
      sh    <= {sh[WORD_W-2:0], 1'b0};
    end else begin
      sdo_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ftx_serial_tx.sv
module ftx_serial_tx #(
  parameter int FRAME_CYCLES   = 256,
  parameter int STARTUP_CYCLES = 40,
  parameter int WORD_W         = 16
) (
  input  logic              sclk,
  input  logic              rst,
  input  logic              pwr_ana_ok,
  input  logic              pwr_dig_ok,
  input  logic              s_valid,
  input  logic [WORD_W-1:0] s_data,
  output logic              s_ready,
  output logic              sdo,
  output logic              fsync
);
  logic              en;
  logic              frame_go;
  logic              bit_go;
  logic [WORD_W-1:0] word_next;
  logic              fs_q;

  assign en = pwr_ana_ok & pwr_dig_ok;

  ftx_sequencer #(
    .FRAME_CYCLES  (FRAME_CYCLES),
    .STARTUP_CYCLES(STARTUP_CYCLES),
    .WORD_W        (WORD_W)
  ) u_seq (
    .sclk    (sclk),
    .rst     (rst),
    .en      (en),
    .frame_go(frame_go),
    .bit_go  (bit_go)
  );

  ftx_word_hold #(.WORD_W(WORD_W)) u_hold (
    .sclk     (sclk),
    .rst      (rst),
    .take     (frame_go),
    .s_valid  (s_valid),
    .s_data   (s_data),
    .word_next(word_next)
  );

  ftx_shifter #(.WORD_W(WORD_W)) u_shift (
    .sclk     (sclk),
    .rst      (rst),
    .load     (frame_go),
    .load_word(word_next),
    .shift    (bit_go),
    .sdo_q    (sdo)
  );

  always_ff @(posedge sclk) begin
    if (rst) fs_q <= 1'b0;
    else     fs_q <= frame_go;
  end

  assign fsync   = fs_q;
  assign s_ready = frame_go;
endmodule

// File: rtl/ftx_serial_tx_chk.sv
module ftx_serial_tx_chk #(
  parameter int FRAME_CYCLES = 256,
  parameter int WORD_W       = 16
) (
  input logic sclk,
  input logic rst,
  input logic pwr_ana_ok,
  input logic pwr_dig_ok,
  input logic s_ready,
  input logic sdo,
  input logic fsync
);
  localparam int GW = $clog2(FRAME_CYCLES) + 2;
  logic [GW-1:0] gap;

  always_ff @(posedge sclk) begin
    if (rst)                        gap <= '0;
    else if (fsync)                 gap <= GW'(1);
    else if (gap != '0 && gap != '1) gap <= gap + 1'b1;
  end

  // R4
  fs_single_chk: assert property (@(posedge sclk) disable iff (rst)
    fsync |=> !fsync);

  // R1
  fs_enable_chk: assert property (@(posedge sclk) disable iff (rst)
    fsync |-> $past(pwr_ana_ok && pwr_dig_ok));

  // R6
  ready_frame_chk: assert property (@(posedge sclk) disable iff (rst)
    s_ready |=> fsync);

  // R3
  fs_spacing_chk: assert property (@(posedge sclk) disable iff (rst)
    fsync |-> (gap == '0 || gap >= GW'(FRAME_CYCLES)));

  // R5
  sdo_slot_chk: assert property (@(posedge sclk) disable iff (rst)
    sdo |-> (gap >= GW'(1) && gap <= GW'(WORD_W)));
endmodule

bind ftx_serial_tx ftx_serial_tx_chk #(
  .FRAME_CYCLES(FRAME_CYCLES),
  .WORD_W      (WORD_W)
) u_chk (
  .sclk      (sclk),
  .rst       (rst),
  .pwr_ana_ok(pwr_ana_ok),
  .pwr_dig_ok(pwr_dig_ok),
  .s_ready   (s_ready),
  .sdo       (sdo),
  .fsync     (fsync)
);

// File: tb/tb_ftx_serial_tx.sv
module tb_ftx_serial_tx;
  localparam int FRAME = 256;
  localparam int SU    = 40;
  localparam int W     = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         pa = 1'b0, pd = 1'b0;
  logic         s_valid = 1'b0;
  logic [W-1:0] s_data = '0;
  logic         s_ready, sdo, fsync;

  always #10 clk = ~clk;

  ftx_serial_tx #(.FRAME_CYCLES(FRAME), .STARTUP_CYCLES(SU), .WORD_W(W)) dut (
    .sclk(clk), .rst(rst), .pwr_ana_ok(pa), .pwr_dig_ok(pd),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .sdo(sdo), .fsync(fsync));

  int checks = 0, fails = 0;
  int cyc = 0, fs_count = 0, last_fs = 0, ready_cyc = -10, idx = 0;
  bit gap_ok = 0, collecting = 0, prev_fs = 0, rnd_on = 0, done = 0;
  logic [W-1:0] latched = '0, frame_exp = '0, acc = '0, rx_word = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit enabled();
    return pa && pd;
  endfunction

  // One bit-clock step: observe after the rising edge, then drive the next inputs.
  task automatic step();
    @(negedge clk);
    cyc++;
    if (fsync) begin
      check(!prev_fs, "R4", 32'(prev_fs), 0);
      check(!collecting, "R5", 32'(collecting), 0);
      check(ready_cyc == cyc - 1, "R6", 32'(ready_cyc), 32'(cyc - 1));
      if (gap_ok) check(cyc - last_fs == FRAME, "R3", 32'(cyc - last_fs), FRAME);
      gap_ok = 1; last_fs = cyc; fs_count++;
      frame_exp = latched; collecting = 1; idx = 0; acc = '0;
    end else if (collecting) begin
      acc = {acc[W-2:0], sdo};
      idx++;
      if (idx == W) begin
        check(acc == frame_exp, "R5", 32'(acc), 32'(frame_exp));
        rx_word = acc;
        collecting = 0;
      end
    end else if (sdo) begin
      check(1'b0, "R5", 32'(sdo), 0);
    end
    prev_fs = fsync;
    if (rnd_on) begin
      s_valid = ($urandom % 3) == 0;
      s_data  = W'($urandom);
    end
    #1;
    if (s_ready) begin
      ready_cyc = cyc;
      if (!enabled()) check(1'b0, "R1", 32'(s_ready), 0);
      if (s_valid) latched = s_data;
    end
  endtask

  task automatic measure_startup(input string req);
    int n = 0;
    do begin
      step();
      n++;
    end while (!fsync && n < SU + FRAME);
    check(n == SU + 2, req, 32'(n), SU + 2);
  endtask

  task automatic wait_frames(input int k);
    repeat (k * FRAME) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    logic [W-1:0] rx_a;
    void'($urandom(32'd7781));
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!fsync && !sdo && !s_ready, "R9", {29'd0, fsync, sdo, s_ready}, 0);
    rst = 1'b0;

    // R1: one enable at a time produces nothing
    pa = 1'b1; pd = 1'b0;
    base = fs_count;
    repeat (SU + FRAME) step();
    check(fs_count == base, "R1", 32'(fs_count), 32'(base));
    pa = 1'b0; pd = 1'b1;
    repeat (SU + FRAME) step();
    check(fs_count == base, "R1", 32'(fs_count), 32'(base));

    // R2: warm-up latency; R7: first word is zero with no sample offered
    pa = 1'b1;
    measure_startup("R2");
    repeat (W + 1) step();
    check(rx_word == '0, "R7", 32'(rx_word), 0);

    // Directed corner words
    s_valid = 1'b1; s_data = 16'h8001;
    wait_frames(1);
    s_valid = 1'b0;
    wait_frames(1);
    rx_a = rx_word;
    check(rx_a == 16'h8001, "R6", 32'(rx_a), 32'h8001);
    wait_frames(1);
    check(rx_word == rx_a, "R7", 32'(rx_word), 32'(rx_a));
    s_valid = 1'b1; s_data = 16'hFFFF;
    wait_frames(2);
    check(rx_word == 16'hFFFF, "R5", 32'(rx_word), 32'hFFFF);

    // Random samples over many frames (R3, R5, R6, R7 checked per frame)
    rnd_on = 1;
    wait_frames(14);
    rnd_on = 0; s_valid = 1'b0;

    // R8: drop an enable mid-frame
    while (!fsync) step();
    repeat (5) step();
    pd = 1'b0; gap_ok = 0;
    base = fs_count;
    wait_frames(2);
    check(fs_count == base, "R8", 32'(fs_count), 32'(base));
    check(!collecting, "R8", 32'(collecting), 0);
    pd = 1'b1;
    measure_startup("R8");
    wait_frames(1);

    // R2: abort during warm-up, then full restart
    pa = 1'b0; gap_ok = 0;
    wait_frames(1);
    pa = 1'b1;
    repeat (SU / 2) step();
    pa = 1'b0;
    base = fs_count;
    repeat (SU + FRAME) step();
    check(fs_count == base, "R2", 32'(fs_count), 32'(base));
    pa = 1'b1;
    measure_startup("R2");
    wait_frames(2);

    // R9: reset mid-run clears outputs
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(!fsync && !sdo && !s_ready, "R9", {29'd0, fsync, sdo, s_ready}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule